// File: doc/BRIEF.md
# Dynamic Warp Regrouping Pool

This block holds warps that are waiting to issue on a SIMD core. When a warp runs a branch, each branch target is handed in with its PC and the set of lanes that go that way. Each target either joins a pooled warp that is already waiting at the same PC, or takes a free pool entry of its own. It can join only when the two lane sets are disjoint. A thread always stays in its home lane, so a joined warp fills the SIMD lanes without moving any thread. Each lane also records the warp that thread came from. After several merges, one pooled warp can hold threads from several original warps.

On the issue side, the block offers one pooled warp per cycle. It picks the warp whose PC is held by the most active threads across the whole pool. A downstream stage takes the offered warp with a valid/ready handshake, and that pool entry is then released. When the pool cannot place a request, the inserting side is held back. A separate flag shows that every entry is occupied.

Top module: `wrp_regroup_pool`

## Requirements
- R1: After reset the pool is empty: `iss_valid` and `pool_full` are low.
- R2: Each branch target with a nonzero lane mask becomes pool contents at that PC, covering exactly its lanes. A target whose mask is all zero is ignored. Mask bit i stands for lane i.
- R3: A target whose PC equals that of a pooled entry, with no lane in common, is merged into the lowest-indexed such entry. The merged mask is the OR of the two masks.
- R4: A target whose lanes collide with every pooled entry at its PC takes a separate free entry.
- R5: Every thread keeps its home lane. `iss_wids` carries the origin warp id of lane i in bits [i*WID_W +: WID_W], and lanes with a clear mask bit read zero.
- R6: The offered warp belongs to the PC with the largest total active-thread count over all pooled entries. Ties go to the lowest-indexed entry.
- R7: `iss_valid` is high whenever the pool holds an entry. A cycle with `iss_valid` and `iss_ready` both high removes exactly the offered entry.
- R8: `pool_full` is high exactly when every pool entry is occupied.
- R9: `br_ready` is low when a target of the request can neither merge nor find a free entry. A stalled request leaves the pool unchanged. A request that only merges is accepted even when the pool is full.
- R10: The entry being issued in a cycle is neither a merge target nor a free slot for a request accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_valid | input | 1 | A branch outcome is presented |
| br_ready | output | 1 | The presented outcome can be placed this cycle |
| tgt_a_pc | input | PC_W | PC of the first target |
| tgt_a_mask | input | LANES | Lanes going to the first target |
| tgt_b_pc | input | PC_W | PC of the second target |
| tgt_b_mask | input | LANES | Lanes going to the second target |
| br_wids | input | LANES*WID_W | Origin warp id per lane of the branching warp |
| iss_valid | output | 1 | A pooled warp is offered |
| iss_ready | input | 1 | Downstream takes the offered warp |
| iss_pc | output | PC_W | PC of the offered warp |
| iss_mask | output | LANES | Occupied lanes of the offered warp |
| iss_wids | output | LANES*WID_W | Origin warp id per lane of the offered warp |
| pool_full | output | 1 | Every pool entry is occupied |

## Verification
A wrong internal state shows up mostly in the issue stream. A bad merge or a lost lane shows up as a wrong mask or a wrong lane warp id when that entry is issued, which can be many cycles after the faulty insertion. So the scoreboard compares every issued warp, including its order, against values worked out by hand. Faults in occupancy tracking show up sooner, in the very next cycle, as a wrong `pool_full` or an unexpected `br_ready` stall. A leak of the entry that is being issued would appear as an extra or a missing warp when the pool is drained.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  parameter int unsigned WRP_LANES   = 4;
  parameter int unsigned WRP_ENTRIES = 4;
  parameter int unsigned WRP_PC_W    = 8;
  parameter int unsigned WRP_WID_W   = 3;
endpackage

// File: rtl/wrp_slot_find.sv
module wrp_slot_find #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned PC_W    = 8,
  parameter int unsigned LANES   = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]       occ_i,
  input  logic [ENTRIES-1:0]       merge_ok_i,
  input  logic [ENTRIES*PC_W-1:0]  pc_i,
  input  logic [ENTRIES*LANES-1:0] mask_i,
  input  logic [PC_W-1:0]          req_pc_i,
  input  logic [LANES-1:0]         req_mask_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         hit_idx_o,
  output logic                     free_o,
  output logic [IDX_W-1:0]         free_idx_o
);
  logic [ENTRIES-1:0] cand;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cand
    assign cand[e] = occ_i[e] & merge_ok_i[e]
                   & (pc_i[e*PC_W +: PC_W] == req_pc_i)
                   & ~(|(mask_i[e*LANES +: LANES] & req_mask_i));
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (cand[e]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(e);
      end
      if (!occ_i[e]) begin
        free_o     = 1'b1;
        free_idx_o = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/wrp_majority_pick.sv
module wrp_majority_pick #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned PC_W    = 8,
  parameter int unsigned LANES   = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(LANES + 1),
  localparam int unsigned TOT_W  = $clog2(ENTRIES * LANES + 1)
) (
  input  logic [ENTRIES-1:0]       occ_i,
  input  logic [ENTRIES*PC_W-1:0]  pc_i,
  input  logic [ENTRIES*LANES-1:0] mask_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         sel_o
);
  logic [ENTRIES-1:0][CNT_W-1:0] cnt;
  logic [ENTRIES-1:0][TOT_W-1:0] tot;
  logic [TOT_W-1:0]              best;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      cnt[e] = '0;
      if (occ_i[e]) begin
        for (int l = 0; l < LANES; l++) begin
          cnt[e] = cnt[e] + CNT_W'(mask_i[e*LANES + l]);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tot[i] = '0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (occ_i[j] && (pc_i[j*PC_W +: PC_W] == pc_i[i*PC_W +: PC_W])) begin
          tot[i] = tot[i] + TOT_W'(cnt[j]);
        end
      end
    end
  end

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    best  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (occ_i[i] && (!any_o || (tot[i] > best))) begin
        any_o = 1'b1;
        sel_o = IDX_W'(i);
        best  = tot[i];
      end
    end
  end
endmodule

// File: rtl/wrp_regroup_pool.sv
module wrp_regroup_pool #(
  parameter int unsigned LANES   = wrp_pkg::WRP_LANES,
  parameter int unsigned ENTRIES = wrp_pkg::WRP_ENTRIES,
  parameter int unsigned PC_W    = wrp_pkg::WRP_PC_W,
  parameter int unsigned WID_W   = wrp_pkg::WRP_WID_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned LW_W   = LANES * WID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  output logic             br_ready,
  input  logic [PC_W-1:0]  tgt_a_pc,
  input  logic [LANES-1:0] tgt_a_mask,
  input  logic [PC_W-1:0]  tgt_b_pc,
  input  logic [LANES-1:0] tgt_b_mask,
  input  logic [LW_W-1:0]  br_wids,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [PC_W-1:0]  iss_pc,
  output logic [LANES-1:0] iss_mask,
  output logic [LW_W-1:0]  iss_wids,
  output logic             pool_full
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [ENTRIES-1:0]            occ_q, occ_d, occ_m, occ_f;
  logic [ENTRIES-1:0][PC_W-1:0]  pc_q,  pc_d,  pc_m,  pc_f;
  logic [ENTRIES-1:0][LANES-1:0] msk_q, msk_d, msk_m, msk_f;
  logic [ENTRIES-1:0][LW_W-1:0]  wid_q, wid_d, wid_m, wid_f;

  function automatic logic [LW_W-1:0] lane_merge(
    input logic [LW_W-1:0] old_w, input logic [LW_W-1:0] new_w,
    input logic [LANES-1:0] sel);
    logic [LW_W-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      r[l*WID_W +: WID_W] = sel[l] ? new_w[l*WID_W +: WID_W] : old_w[l*WID_W +: WID_W];
    end
    return r;
  endfunction

  // issue selection
  logic             iss_any, iss_fire;
  logic [IDX_W-1:0] sel_idx;
  logic [ENTRIES-1:0] merge_ok;

  wrp_majority_pick #(.ENTRIES(ENTRIES), .PC_W(PC_W), .LANES(LANES)) u_pick (
    .occ_i (occ_q), .pc_i (pc_q), .mask_i (msk_q),
    .any_o (iss_any), .sel_o (sel_idx)
  );

  assign iss_valid = iss_any;
  assign iss_pc    = pc_q[sel_idx];
  assign iss_mask  = msk_q[sel_idx];
  assign iss_wids  = wid_q[sel_idx];
  assign iss_fire  = iss_valid & iss_ready;
  assign merge_ok  = iss_fire ? ~(ENTRIES'(1) << sel_idx) : '1;
  assign pool_full = &occ_q;

  // first target against the current pool
  logic             hit_a, free_a, need_a, ok_a;
  logic [IDX_W-1:0] hit_idx_a, free_idx_a, idx_a;

  wrp_slot_find #(.ENTRIES(ENTRIES), .PC_W(PC_W), .LANES(LANES)) u_find_a (
    .occ_i (occ_q), .merge_ok_i (merge_ok), .pc_i (pc_q), .mask_i (msk_q),
    .req_pc_i (tgt_a_pc), .req_mask_i (tgt_a_mask),
    .hit_o (hit_a), .hit_idx_o (hit_idx_a), .free_o (free_a), .free_idx_o (free_idx_a)
  );

  assign need_a = |tgt_a_mask;
  assign ok_a   = ~need_a | hit_a | free_a;
  assign idx_a  = hit_a ? hit_idx_a : free_idx_a;

  always_comb begin
    occ_m = occ_q;
    pc_m  = pc_q;
    msk_m = msk_q;
    wid_m = wid_q;
    if (need_a && ok_a) begin
      occ_m[idx_a] = 1'b1;
      pc_m[idx_a]  = tgt_a_pc;
      if (hit_a) begin
        msk_m[idx_a] = msk_q[idx_a] | tgt_a_mask;
        wid_m[idx_a] = lane_merge(wid_q[idx_a], br_wids, tgt_a_mask);
      end else begin
        msk_m[idx_a] = tgt_a_mask;
        wid_m[idx_a] = lane_merge('0, br_wids, tgt_a_mask);
      end
    end
  end

  // second target against the pool as left by the first
  logic             hit_b, free_b, need_b, ok_b;
  logic [IDX_W-1:0] hit_idx_b, free_idx_b, idx_b;

  wrp_slot_find #(.ENTRIES(ENTRIES), .PC_W(PC_W), .LANES(LANES)) u_find_b (
    .occ_i (occ_m), .merge_ok_i (merge_ok), .pc_i (pc_m), .mask_i (msk_m),
    .req_pc_i (tgt_b_pc), .req_mask_i (tgt_b_mask),
    .hit_o (hit_b), .hit_idx_o (hit_idx_b), .free_o (free_b), .free_idx_o (free_idx_b)
  );

  assign need_b = |tgt_b_mask;
  assign ok_b   = ~need_b | hit_b | free_b;
  assign idx_b  = hit_b ? hit_idx_b : free_idx_b;

  always_comb begin
    occ_f = occ_m;
    pc_f  = pc_m;
    msk_f = msk_m;
    wid_f = wid_m;
    if (need_b && ok_b) begin
      occ_f[idx_b] = 1'b1;
      pc_f[idx_b]  = tgt_b_pc;
      if (hit_b) begin
        msk_f[idx_b] = msk_m[idx_b] | tgt_b_mask;
        wid_f[idx_b] = lane_merge(wid_m[idx_b], br_wids, tgt_b_mask);
      end else begin
        msk_f[idx_b] = tgt_b_mask;
        wid_f[idx_b] = lane_merge('0, br_wids, tgt_b_mask);
      end
    end
  end

  assign br_ready = ok_a & ok_b;

  // next state
  logic accept;
  assign accept = br_valid & br_ready;

  always_comb begin
    occ_d = occ_q;
    pc_d  = pc_q;
    msk_d = msk_q;
    wid_d = wid_q;
    if (accept) begin
      occ_d = occ_f;
      pc_d  = pc_f;
      msk_d = msk_f;
      wid_d = wid_f;
    end
    if (iss_fire) begin
      occ_d[sel_idx] = 1'b0;
    end
  end

  logic upd_en;
  assign upd_en = accept | iss_fire;

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      occ_q <= '0;
      pc_q  <= '0;
      msk_q <= '0;
      wid_q <= '0;
    end else if (upd_en) begin
      occ_q <= occ_d;
      pc_q  <= pc_d;
      msk_q <= msk_d;
      wid_q <= wid_d;
    end
  end
endmodule

// File: rtl/wrp_regroup_pool_chk.sv
module wrp_regroup_pool_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned PC_W  = 8,
  parameter int unsigned WID_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   br_valid,
  input logic                   br_ready,
  input logic                   iss_valid,
  input logic                   iss_ready,
  input logic [PC_W-1:0]        iss_pc,
  input logic [LANES-1:0]       iss_mask,
  input logic [LANES*WID_W-1:0] iss_wids,
  input logic                   pool_full
);
  AST_OFFER_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_mask != '0)) else $error("offered warp with no lanes"); // R2

  AST_FULL_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> iss_valid) else $error("full pool offers nothing"); // R8

  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid && !(br_valid && br_ready)) |=> !iss_valid) else $error("warp appeared from nowhere"); // R7

  AST_STALL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !br_ready |-> iss_valid) else $error("stall with an empty pool"); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_ready && !(iss_valid && iss_ready))
      |=> ($stable(iss_pc) && $stable(iss_mask) && $stable(iss_wids) && $stable(pool_full)))
    else $error("stalled request changed the pool"); // R9

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_mask[l]) |-> (iss_wids[l*WID_W +: WID_W] == '0))
      else $error("inactive lane carries a warp id"); // R5
  end
endmodule

bind wrp_regroup_pool wrp_regroup_pool_chk #(.LANES(LANES), .PC_W(PC_W), .WID_W(WID_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .br_valid (br_valid), .br_ready (br_ready),
  .iss_valid (iss_valid), .iss_ready (iss_ready), .iss_pc (iss_pc),
  .iss_mask (iss_mask), .iss_wids (iss_wids), .pool_full (pool_full)
);

// File: tb/wrp_regroup_pool_bench.sv
module wrp_regroup_pool_bench;
  localparam int LANES = 4;
  localparam int PC_W  = 8;
  localparam int WID_W = 3;
  localparam int LW_W  = LANES * WID_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             br_valid = 1'b0;
  logic             br_ready;
  logic [PC_W-1:0]  tgt_a_pc = '0, tgt_b_pc = '0;
  logic [LANES-1:0] tgt_a_mask = '0, tgt_b_mask = '0;
  logic [LW_W-1:0]  br_wids = '0;
  logic             iss_valid;
  logic             iss_ready = 1'b0;
  logic [PC_W-1:0]  iss_pc;
  logic [LANES-1:0] iss_mask;
  logic [LW_W-1:0]  iss_wids;
  logic             pool_full;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] mask;
    logic [LW_W-1:0]  wids;
    logic [7:0]       req;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  wrp_regroup_pool u_wrp_regroup_pool (
    .clk (clk), .rst_n (rst_n), .br_valid (br_valid), .br_ready (br_ready),
    .tgt_a_pc (tgt_a_pc), .tgt_a_mask (tgt_a_mask),
    .tgt_b_pc (tgt_b_pc), .tgt_b_mask (tgt_b_mask), .br_wids (br_wids),
    .iss_valid (iss_valid), .iss_ready (iss_ready), .iss_pc (iss_pc),
    .iss_mask (iss_mask), .iss_wids (iss_wids), .pool_full (pool_full)
  );

  function automatic logic [LW_W-1:0] rep(input logic [WID_W-1:0] w);
    return {LANES{w}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_issue(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m,
                              input logic [LW_W-1:0] w, input logic [7:0] r);
    item_t it;
    it.pc = pc; it.mask = m; it.wids = w; it.req = r;
    exp_q.push_back(it);
  endtask

  // driver: one branch outcome, held for one clock edge
  task automatic send(input logic [PC_W-1:0] pa, input logic [LANES-1:0] ma,
                      input logic [PC_W-1:0] pb, input logic [LANES-1:0] mb,
                      input logic [LW_W-1:0] w);
    @(negedge clk);
    br_valid = 1'b1; tgt_a_pc = pa; tgt_a_mask = ma;
    tgt_b_pc = pb; tgt_b_mask = mb; br_wids = w;
    @(negedge clk);
    br_valid = 1'b0; tgt_a_mask = '0; tgt_b_mask = '0;
  endtask

  task automatic drain();
    @(negedge clk);
    iss_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    iss_ready = 1'b0;
    #3;
    check("R7 empty after drain", {31'd0, iss_valid}, 32'd0);
  endtask

  // monitor: compare each issued warp with the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (iss_valid && iss_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected issue actual pc=0x%0h mask=%b expected none", iss_pc, iss_mask);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check($sformatf("R%0d issue pc", e.req), {24'd0, iss_pc}, {24'd0, e.pc});
          check($sformatf("R%0d issue mask", e.req), {28'd0, iss_mask}, {28'd0, e.mask});
          check("R5 issue lane warp ids", {20'd0, iss_wids}, {20'd0, e.wids});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1 reset state
    check("R1 iss_valid after reset", {31'd0, iss_valid}, 32'd0);
    check("R1 pool_full after reset", {31'd0, pool_full}, 32'd0);
    check("R9 ready when empty", {31'd0, br_ready}, 32'd1);

    // split of two warps; R3 merge at 0x10, R4 conflict at 0x20
    send(8'h10, 4'b0110, 8'h20, 4'b1001, rep(3'd0));
    send(8'h10, 4'b0001, 8'h20, 4'b1110, rep(3'd1));
    #3;
    check("R8 not full with three entries", {31'd0, pool_full}, 32'd0);
    check("R7 valid when occupied", {31'd0, iss_valid}, 32'd1);
    check("R6 majority PC offered first", {24'd0, iss_pc}, 32'h20);
    // R6 PC 0x20 holds 5 threads; then a 3-to-3 tie goes to lower entry
    expect_issue(8'h20, 4'b1001, 12'h000, 8'd6);
    expect_issue(8'h10, 4'b0111, 12'h001, 8'd3);
    expect_issue(8'h20, 4'b1110, 12'h248, 8'd4);
    drain();

    // fill the pool, stall, then merge while full
    send(8'h30, 4'b0001, 8'h40, 4'b1110, rep(3'd2));
    send(8'h50, 4'b0011, 8'h60, 4'b1100, rep(3'd3));
    #3;
    check("R8 full with four entries", {31'd0, pool_full}, 32'd1);
    @(negedge clk);
    br_valid = 1'b1; tgt_a_pc = 8'h70; tgt_a_mask = 4'b1111; tgt_b_mask = '0; br_wids = rep(3'd7);
    #2;
    check("R9 stall when no slot", {31'd0, br_ready}, 32'd0);
    @(negedge clk);
    tgt_a_pc = 8'h30; tgt_a_mask = 4'b0110; br_wids = rep(3'd4);
    #2;
    check("R9 merge accepted while full", {31'd0, br_ready}, 32'd1);
    @(negedge clk);
    br_valid = 1'b0; tgt_a_mask = '0;
    #2;
    check("R8 still full after merge", {31'd0, pool_full}, 32'd1);
    // stalled 0x70 request must never appear
    expect_issue(8'h30, 4'b0111, 12'h122, 8'd3);
    expect_issue(8'h40, 4'b1110, 12'h490, 8'd6);
    expect_issue(8'h50, 4'b0011, 12'h01B, 8'd6);
    expect_issue(8'h60, 4'b1100, 12'h6C0, 8'd2);
    drain();

    // R10 insert in the same cycle as the matching entry issues; R2 zero-mask target ignored
    send(8'h80, 4'b0011, 8'h90, 4'b0000, rep(3'd5));
    expect_issue(8'h80, 4'b0011, 12'h02D, 8'd10);
    expect_issue(8'h80, 4'b1100, 12'hD80, 8'd10);
    @(negedge clk);
    iss_ready = 1'b1;
    br_valid = 1'b1; tgt_a_pc = 8'h80; tgt_a_mask = 4'b1100; tgt_b_mask = '0; br_wids = rep(3'd6);
    @(negedge clk);
    br_valid = 1'b0; tgt_a_mask = '0;
    while (exp_q.size() != 0) @(negedge clk);
    iss_ready = 1'b0;
    #3;
    check("R2 no entry from zero-mask target", {31'd0, iss_valid}, 32'd0);
    check("R8 not full at end", {31'd0, pool_full}, 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule